// File: doc/BRIEF.md
# Narrow-bus word packer and unpacker

This block joins a 32-bit internal data path to an external memory data bus that is 8 or 16 bits wide. On the read side it takes successive narrow beats from the bus and builds full 32-bit words from them. On the write side it takes a 32-bit word and hands it out as a series of narrow beats. Each beat on the narrow side moves on a single strobe. The 32-bit side uses a valid/ready handshake.

Three static configuration inputs control the conversion. The first selects the bus width. The second selects whether the first beat lands in the low or the high part of the word. The third turns packing off. With packing off, every read beat becomes a zero-extended word of its own, and every write sends only the low byte of the word, as a single beat. A one-cycle pulse marks each completed packed word. Another one-cycle pulse marks the end of each unpack sequence.

The bus controller that owns strobes, wait states and addresses sits outside the block. It presents read beats to the block and acknowledges write beats. The block never drives bus timing itself.

Top module: `bus_pack_unit`

## Requirements
- R1: After reset, rd_word_valid, wr_beat_valid, pack_done and unpack_done are 0, and rd_beat_ready and wr_word_ready are 1.
- R2: With packing on and cfg_bus16=1, two accepted read beats form one word. Lane k is bits [16k+15:16k], and only rd_beat_data[15:0] is used.
- R3: With packing on and cfg_bus16=0, four accepted read beats form one word. Lane k is bits [8k+7:8k], and only rd_beat_data[7:0] is used. The upper byte of rd_beat_data is ignored.
- R4: With cfg_msb_first=0, read beat number i (counting from 0) fills lane i. With cfg_msb_first=1, it fills lane N-1-i, where N is the number of beats per word.
- R5: With cfg_pack_off=1, each read beat yields one word on its own. That word is the beat zero-extended above the bus width (8 or 16 bits), and cfg_msb_first has no effect.
- R6: With packing on, an accepted write word is sent as N beats (N is 2 or 4). Beat i carries lane i when cfg_msb_first=0 and lane N-1-i when it is 1. The beat sits in the low bits of wr_beat_data, and the unused high bits are 0.
- R7: With cfg_pack_off=1, an accepted write word is sent as one beat equal to {8'h00, word[7:0]}, whatever the bus width or order setting.
- R8: wr_word_ready is 0 from the word's acceptance until the edge that takes the last wr_beat_ack. It is 1 again after that edge, and unpack_done is 1 for exactly that one cycle. An unacknowledged beat holds its data.
- R9: A word appears one cycle after its final beat, with pack_done high for that one cycle. The word is held unchanged until rd_word_ready is 1. rd_beat_ready is 0 while the word is held.
- R10: Any change on the configuration inputs discards a partly built read word. The next read beat becomes beat 0 of a new word.
- R11: The write configuration is captured when a word is accepted. Changes made while that word's beats are in progress do not alter those beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_pack_off | input | 1 | 1 = no packing (zero-fill reads, low-byte writes) |
| cfg_msb_first | input | 1 | 1 = first beat in the most significant lane |
| cfg_bus16 | input | 1 | 1 = 16-bit external bus, 0 = 8-bit |
| rd_beat_valid | input | 1 | Read beat strobe from the bus side |
| rd_beat_data | input | 16 | Read beat data |
| rd_beat_ready | output | 1 | Block can take a read beat |
| rd_word_valid | output | 1 | Assembled 32-bit word available |
| rd_word_data | output | 32 | Assembled word |
| rd_word_ready | input | 1 | Consumer takes the word |
| pack_done | output | 1 | One-cycle pulse when a word completes |
| wr_word_valid | input | 1 | Write word offered |
| wr_word_data | input | 32 | Write word |
| wr_word_ready | output | 1 | Block can take a write word |
| wr_beat_valid | output | 1 | Write beat presented |
| wr_beat_data | output | 16 | Write beat data |
| wr_beat_ack | input | 1 | Bus side takes the current write beat |
| unpack_done | output | 1 | One-cycle pulse after the last write beat |

## Verification
The bench drives noise on the unused upper byte of an 8-bit bus. A packer that failed to mask it would corrupt neighbouring lanes. Every width, order and bypass combination is checked on both paths. A swapped lane index would reverse the words, and a bypass that honoured the order bit would put the byte at the top of the word. A configuration change in the middle of a word is checked to start a fresh word; a design that kept stale beats would output a mix of the old and new settings. The bench also changes the configuration in the middle of an unpack, which catches a design that reads the live inputs. It stalls acknowledgements and the word consumer, which catches beats or words that change or get lost while held.

// File: rtl/bpu_pkg.sv
package bpu_pkg;
  typedef struct packed {
    logic bypass;
    logic msb_first;
    logic wide;
  } bpu_cfg_t;
endpackage

// File: rtl/bpu_rst_sync.sv
module bpu_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/bpu_cfg_track.sv
module bpu_cfg_track
  import bpu_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  bpu_cfg_t cfg,
  output logic     cfg_chg
);
  bpu_cfg_t cfg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg;
  end

  assign cfg_chg = (cfg != cfg_q);
endmodule

// File: rtl/bpu_gather.sv
module bpu_gather
  import bpu_pkg::*;
#(
  parameter int INT_W    = 32,
  parameter int EXT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bpu_cfg_t         cfg,
  input  logic             cfg_chg,
  input  logic             beat_valid,
  input  logic [EXT_W-1:0] beat_data,
  output logic             beat_ready,
  output logic             word_valid,
  output logic [INT_W-1:0] word_data,
  input  logic             word_ready,
  output logic             pack_done
);
  localparam int WIDE_BEATS   = INT_W / EXT_W;
  localparam int NARROW_BEATS = INT_W / NARROW_W;
  localparam int CW           = $clog2(NARROW_BEATS);
  localparam int SW           = $clog2(INT_W);

  logic [CW-1:0]    cnt_q, cnt_d, cnt_eff, last_idx, pos;
  logic [SW-1:0]    shamt;
  logic [EXT_W-1:0] nmask;
  logic [INT_W-1:0] asm_q, asm_d, base, field, fmask;
  logic [INT_W-1:0] word_q, word_d;
  logic             valid_q, valid_d, done_d, done_q;
  logic             take, last_beat;
  logic             cnt_en, asm_en, word_en;

  // beat position inside the word
  always_comb begin
    last_idx  = cfg.wide ? CW'(WIDE_BEATS - 1) : CW'(NARROW_BEATS - 1);
    cnt_eff   = cfg_chg ? '0 : cnt_q;
    take      = beat_valid && beat_ready;
    last_beat = cfg.bypass || (cnt_eff == last_idx);
    if (cfg.bypass)         pos = '0;
    else if (cfg.msb_first) pos = last_idx - cnt_eff;
    else                    pos = cnt_eff;
    shamt = SW'(pos) * (cfg.wide ? SW'(EXT_W) : SW'(NARROW_W));
    nmask = cfg.wide ? {EXT_W{1'b1}} : EXT_W'({NARROW_W{1'b1}});
  end

  // lane merge
  always_comb begin
    field = INT_W'(beat_data & nmask) << shamt;
    fmask = INT_W'(nmask) << shamt;
    base  = (cnt_eff == '0) ? '0 : asm_q;
    asm_d = (base & ~fmask) | field;
  end

  // next state
  always_comb begin
    cnt_en  = take || cfg_chg;
    cnt_d   = (take && !last_beat) ? cnt_eff + CW'(1) : '0;
    asm_en  = take;
    word_en = take && last_beat;
    word_d  = asm_d;
    if (word_en)                  valid_d = 1'b1;
    else if (valid_q && word_ready) valid_d = 1'b0;
    else                          valid_d = valid_q;
    done_d = word_en;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      asm_q   <= '0;
      word_q  <= '0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (asm_en)  asm_q  <= asm_d;
      if (word_en) word_q <= word_d;
      valid_q <= valid_d;
      done_q  <= done_d;
    end
  end

  assign beat_ready = !valid_q;
  assign word_valid = valid_q;
  assign word_data  = word_q;
  assign pack_done  = done_q;
endmodule

// File: rtl/bpu_scatter.sv
module bpu_scatter
  import bpu_pkg::*;
#(
  parameter int INT_W    = 32,
  parameter int EXT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  bpu_cfg_t         cfg,
  input  logic             word_valid,
  input  logic [INT_W-1:0] word_data,
  output logic             word_ready,
  output logic             beat_valid,
  output logic [EXT_W-1:0] beat_data,
  input  logic             beat_ack,
  output logic             unpack_done
);
  localparam int WIDE_BEATS   = INT_W / EXT_W;
  localparam int NARROW_BEATS = INT_W / NARROW_W;
  localparam int CW           = $clog2(NARROW_BEATS);
  localparam int SW           = $clog2(INT_W);

  bpu_cfg_t         lcfg_q;
  logic [INT_W-1:0] word_q;
  logic [CW-1:0]    cnt_q, cnt_d, last_idx, pos;
  logic [SW-1:0]    shamt;
  logic [EXT_W-1:0] nmask;
  logic             busy_q, busy_d, done_d, done_q;
  logic             accept, step, last_beat, load_en, cnt_en;

  // beat selection from the captured configuration
  always_comb begin
    last_idx  = lcfg_q.wide ? CW'(WIDE_BEATS - 1) : CW'(NARROW_BEATS - 1);
    last_beat = lcfg_q.bypass || (cnt_q == last_idx);
    if (lcfg_q.bypass)         pos = '0;
    else if (lcfg_q.msb_first) pos = last_idx - cnt_q;
    else                       pos = cnt_q;
    shamt = SW'(pos) * (lcfg_q.wide ? SW'(EXT_W) : SW'(NARROW_W));
    nmask = lcfg_q.wide ? {EXT_W{1'b1}} : EXT_W'({NARROW_W{1'b1}});
    if (lcfg_q.bypass) beat_data = EXT_W'(word_q[NARROW_W-1:0]);
    else               beat_data = EXT_W'(word_q >> shamt) & nmask;
  end

  // next state
  always_comb begin
    accept  = word_valid && !busy_q;
    step    = busy_q && beat_ack;
    load_en = accept;
    cnt_en  = accept || step;
    cnt_d   = (step && !last_beat) ? cnt_q + CW'(1) : '0;
    if (accept)                 busy_d = 1'b1;
    else if (step && last_beat) busy_d = 1'b0;
    else                        busy_d = busy_q;
    done_d = step && last_beat;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lcfg_q <= '0;
      word_q <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      if (load_en) begin
        lcfg_q <= cfg;
        word_q <= word_data;
      end
      if (cnt_en) cnt_q <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign word_ready  = !busy_q;
  assign beat_valid  = busy_q;
  assign unpack_done = done_q;
endmodule

// File: rtl/bus_pack_unit.sv
module bus_pack_unit
  import bpu_pkg::*;
#(
  parameter int INT_W    = 32,
  parameter int EXT_W    = 16,
  parameter int NARROW_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_pack_off,
  input  logic             cfg_msb_first,
  input  logic             cfg_bus16,
  input  logic             rd_beat_valid,
  input  logic [EXT_W-1:0] rd_beat_data,
  output logic             rd_beat_ready,
  output logic             rd_word_valid,
  output logic [INT_W-1:0] rd_word_data,
  input  logic             rd_word_ready,
  output logic             pack_done,
  input  logic             wr_word_valid,
  input  logic [INT_W-1:0] wr_word_data,
  output logic             wr_word_ready,
  output logic             wr_beat_valid,
  output logic [EXT_W-1:0] wr_beat_data,
  input  logic             wr_beat_ack,
  output logic             unpack_done
);
  bpu_cfg_t cfg;
  logic     rst_n_s;
  logic     cfg_chg;

  assign cfg = '{bypass: cfg_pack_off, msb_first: cfg_msb_first, wide: cfg_bus16};

  bpu_rst_sync u_rst (
    .clk      (clk),
    .rst_n_in (rst_n),
    .rst_n_out(rst_n_s)
  );

  bpu_cfg_track u_cfg (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .cfg    (cfg),
    .cfg_chg(cfg_chg)
  );

  bpu_gather #(.INT_W(INT_W), .EXT_W(EXT_W), .NARROW_W(NARROW_W)) u_gather (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .cfg       (cfg),
    .cfg_chg   (cfg_chg),
    .beat_valid(rd_beat_valid),
    .beat_data (rd_beat_data),
    .beat_ready(rd_beat_ready),
    .word_valid(rd_word_valid),
    .word_data (rd_word_data),
    .word_ready(rd_word_ready),
    .pack_done (pack_done)
  );

  bpu_scatter #(.INT_W(INT_W), .EXT_W(EXT_W), .NARROW_W(NARROW_W)) u_scatter (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .cfg        (cfg),
    .word_valid (wr_word_valid),
    .word_data  (wr_word_data),
    .word_ready (wr_word_ready),
    .beat_valid (wr_beat_valid),
    .beat_data  (wr_beat_data),
    .beat_ack   (wr_beat_ack),
    .unpack_done(unpack_done)
  );
endmodule

// File: rtl/bus_pack_unit_chk.sv
module bus_pack_unit_chk #(
  parameter int INT_W    = 32,
  parameter int EXT_W    = 16,
  parameter int NARROW_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_pack_off,
  input logic             cfg_bus16,
  input logic             rd_beat_ready,
  input logic             rd_word_valid,
  input logic [INT_W-1:0] rd_word_data,
  input logic             rd_word_ready,
  input logic             pack_done,
  input logic             wr_word_ready,
  input logic             wr_beat_valid,
  input logic [EXT_W-1:0] wr_beat_data,
  input logic             wr_beat_ack,
  input logic             unpack_done
);
  // R1: reset holds both sides idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |=> !rd_word_valid && !wr_beat_valid && !pack_done && !unpack_done);

  // R9: held word stays put until taken
  p_word_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word_valid && !rd_word_ready |=> rd_word_valid && $stable(rd_word_data));

  // R9: completion pulse coincides with a valid word
  p_done_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pack_done |-> rd_word_valid);

  // R9: no beat accepted while a word is held
  p_beat_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_word_valid |-> !rd_beat_ready);

  // R8: unacknowledged write beat is held
  p_wr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat_valid && !wr_beat_ack |=> wr_beat_valid && $stable(wr_beat_data));

  // R8: no new word while beats remain
  p_wr_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_beat_valid |-> !wr_word_ready);

  // R8: end pulse follows an acknowledged beat
  p_unpack_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    unpack_done |-> $past(wr_beat_valid && wr_beat_ack) && wr_word_ready);

  // R5: bypass read word is zero above the bus width
  p_bypass_fill_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pack_done && $past(cfg_pack_off) |->
      (rd_word_data[INT_W-1:EXT_W] == '0) &&
      ($past(cfg_bus16) || rd_word_data[EXT_W-1:NARROW_W] == '0));
endmodule

bind bus_pack_unit bus_pack_unit_chk #(.INT_W(INT_W), .EXT_W(EXT_W), .NARROW_W(NARROW_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cfg_pack_off (cfg_pack_off),
  .cfg_bus16    (cfg_bus16),
  .rd_beat_ready(rd_beat_ready),
  .rd_word_valid(rd_word_valid),
  .rd_word_data (rd_word_data),
  .rd_word_ready(rd_word_ready),
  .pack_done    (pack_done),
  .wr_word_ready(wr_word_ready),
  .wr_beat_valid(wr_beat_valid),
  .wr_beat_data (wr_beat_data),
  .wr_beat_ack  (wr_beat_ack),
  .unpack_done  (unpack_done)
);

// File: tb/sim_bus_pack_unit.sv
module sim_bus_pack_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_pack_off, cfg_msb_first, cfg_bus16;
  logic        rd_beat_valid, rd_beat_ready, rd_word_valid, rd_word_ready, pack_done;
  logic [15:0] rd_beat_data;
  logic [31:0] rd_word_data;
  logic        wr_word_valid, wr_word_ready, wr_beat_valid, wr_beat_ack, unpack_done;
  logic [31:0] wr_word_data;
  logic [15:0] wr_beat_data;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  bus_pack_unit u0 (.*);

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected packed word; beats holds beat i in bits [16i+15:16i]
  function automatic logic [31:0] exp_pack(input logic [63:0] beats, input logic b16,
                                           input logic msb, input logic off);
    logic [31:0] r;
    int n, w;
    r = '0;
    n = b16 ? 2 : 4;
    w = b16 ? 16 : 8;
    if (off) return b16 ? {16'h0, beats[15:0]} : {24'h0, beats[7:0]};
    for (int k = 0; k < n; k++) begin
      int p;
      logic [31:0] lane;
      p = msb ? n - 1 - k : k;
      lane = b16 ? {16'h0, beats[16*k +: 16]} : {24'h0, beats[16*k +: 8]};
      r = r | (lane << (p * w));
    end
    return r;
  endfunction

  function automatic logic [15:0] exp_beat(input logic [31:0] wd, input int k,
                                           input logic b16, input logic msb, input logic off);
    int n, w, p;
    if (off) return {8'h0, wd[7:0]};
    n = b16 ? 2 : 4;
    w = b16 ? 16 : 8;
    p = msb ? n - 1 - k : k;
    return b16 ? wd[16*p +: 16] : {8'h0, wd[8*p +: 8]};
  endfunction

  task automatic rd_beat(input logic [15:0] d);
    @(negedge clk);
    rd_beat_valid = 1'b1;
    rd_beat_data  = d;
    @(negedge clk);
    rd_beat_valid = 1'b0;
  endtask

  // read one word under the current configuration and check it
  task automatic rd_word(input string tag, input int stall);
    logic [63:0] beats;
    int n;
    logic [31:0] exp;
    n = cfg_pack_off ? 1 : (cfg_bus16 ? 2 : 4);
    beats = {$urandom, $urandom};
    for (int k = 0; k < n; k++) rd_beat(beats[16*k +: 16]);
    exp = exp_pack(beats, cfg_bus16, cfg_msb_first, cfg_pack_off);
    chk(rd_word_valid && pack_done, {tag, " word valid with pulse"}, {30'h0, rd_word_valid, pack_done}, 32'h3);
    chk(rd_word_data == exp, tag, rd_word_data, exp);
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk(rd_word_valid && !pack_done && !rd_beat_ready && rd_word_data == exp,
          "R9 held word", rd_word_data, exp);
    end
    rd_word_ready = 1'b1;
    @(negedge clk);
    rd_word_ready = 1'b0;
    chk(!rd_word_valid && rd_beat_ready, "R9 word released", {31'h0, rd_word_valid}, 32'h0);
  endtask

  // write one word; optionally flip config after the first beat (R11)
  task automatic wr_word(input string tag, input logic [31:0] wd, input int gap, input logic flip);
    logic b16, msb, off;
    int n;
    b16 = cfg_bus16; msb = cfg_msb_first; off = cfg_pack_off;
    n = off ? 1 : (b16 ? 2 : 4);
    @(negedge clk);
    chk(wr_word_ready, "R8 ready before accept", {31'h0, wr_word_ready}, 32'h1);
    wr_word_valid = 1'b1;
    wr_word_data  = wd;
    @(negedge clk);
    wr_word_valid = 1'b0;
    for (int k = 0; k < n; k++) begin
      for (int g = 0; g < gap; g++) @(negedge clk);
      if (flip && k == 1) begin
        cfg_bus16 = ~cfg_bus16;
        cfg_msb_first = ~cfg_msb_first;
        @(negedge clk);
      end
      chk(wr_beat_valid && !wr_word_ready, "R8 busy during beats", {30'h0, wr_beat_valid, wr_word_ready}, 32'h2);
      chk(wr_beat_data == exp_beat(wd, k, b16, msb, off), tag, {16'h0, wr_beat_data},
          {16'h0, exp_beat(wd, k, b16, msb, off)});
      wr_beat_ack = 1'b1;
      @(negedge clk);
      wr_beat_ack = 1'b0;
    end
    chk(unpack_done && wr_word_ready && !wr_beat_valid, "R8 end pulse", {29'h0, unpack_done, wr_word_ready, wr_beat_valid}, 32'h6);
    @(negedge clk);
    chk(!unpack_done, "R8 end pulse one cycle", {31'h0, unpack_done}, 32'h0);
    if (flip) begin
      cfg_bus16 = b16;
      cfg_msb_first = msb;
    end
  endtask

  task automatic set_cfg(input logic off, input logic msb, input logic b16);
    @(negedge clk);
    cfg_pack_off = off; cfg_msb_first = msb; cfg_bus16 = b16;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0;
    cfg_pack_off = 0; cfg_msb_first = 0; cfg_bus16 = 0;
    rd_beat_valid = 0; rd_beat_data = '0; rd_word_ready = 0;
    wr_word_valid = 0; wr_word_data = '0; wr_beat_ack = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk(!rd_word_valid && !wr_beat_valid && !pack_done && !unpack_done && rd_beat_ready && wr_word_ready,
        "R1 reset state",
        {26'h0, rd_word_valid, wr_beat_valid, pack_done, unpack_done, rd_beat_ready, wr_word_ready}, 32'h3);

    // directed: fixed 8-bit pack LSB first, upper byte noise ignored (R3)
    rd_beat(16'hAA11); rd_beat(16'hBB22); rd_beat(16'hCC33); rd_beat(16'hDD44);
    chk(rd_word_data == 32'h44332211, "R3 8-bit pack lsb first", rd_word_data, 32'h44332211);
    rd_word_ready = 1; @(negedge clk); rd_word_ready = 0;

    // directed: 16-bit pack MSB first (R2, R4)
    set_cfg(0, 1, 1);
    rd_beat(16'h1234); rd_beat(16'h5678);
    chk(rd_word_data == 32'h12345678, "R4 16-bit msb first", rd_word_data, 32'h12345678);
    rd_word_ready = 1; @(negedge clk); rd_word_ready = 0;

    // directed: bypass 8-bit with msb bit set, order ignored (R5)
    set_cfg(1, 1, 0);
    rd_beat(16'hF0A5);
    chk(rd_word_data == 32'h000000A5, "R5 bypass zero fill", rd_word_data, 32'h000000A5);
    rd_word_ready = 1; @(negedge clk); rd_word_ready = 0;

    // directed: config change mid word discards partial (R10)
    set_cfg(0, 0, 0);
    rd_beat(16'h0001); rd_beat(16'h0002);
    chk(!rd_word_valid, "R10 partial word not output", {31'h0, rd_word_valid}, 32'h0);
    set_cfg(0, 0, 1);
    rd_beat(16'hBEEF); rd_beat(16'hCAFE);
    chk(rd_word_valid && rd_word_data == 32'hCAFEBEEF, "R10 fresh word after change", rd_word_data, 32'hCAFEBEEF);
    rd_word_ready = 1; @(negedge clk); rd_word_ready = 0;

    // directed writes (R6, R7) and hold during stalls (R9)
    set_cfg(0, 1, 0);
    wr_word("R6 8-bit unpack msb first", 32'hA1B2C3D4, 2, 1'b0);
    set_cfg(1, 1, 1);
    wr_word("R7 bypass low byte", 32'h12345678, 0, 1'b0);
    set_cfg(0, 0, 0);
    wr_word("R11 config captured at accept", 32'h89ABCDEF, 0, 1'b1);
    rd_word("R9 stalled read", 3);

    // random mix (R2 R3 R4 R5 R6 R7)
    for (int i = 0; i < 60; i++) begin
      set_cfg(($urandom % 4) == 0, $urandom % 2, $urandom % 2);
      rd_word("R2/R3/R4/R5 random read", $urandom % 3);
      wr_word("R6/R7 random write", $urandom, $urandom % 3, ($urandom % 5) == 0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule